// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Register Block

This block holds the digital side of a four-channel, 12-bit digital-to-analog converter. A host reaches it through a simple register port. That port has a write strobe with an address and a data word, and a separate read strobe with its own address. Reads return no data. A read of certain offsets acts as a command.

Each channel has a shadow data register and an active data register. The active register drives the channel's output code. A mode register enables the converters and chooses one of two modes:

- **Buffered mode:** data writes only fill the shadows. One update read then moves all four shadows to the outputs in the same clock edge.
- **Direct mode:** a data write reaches the output at once.

A per-channel control word works the same way. It holds a bipolar flag and a gain flag for each channel. The word is written into a shadow and becomes active only on its own update read. All four channels therefore change range and value together.

Top module: `quad_dac_regs`

## Requirements
- R1: After reset, every channel output code is 0, every bipolar and gain output is 0, and the mode register is 0 (converters disabled, direct mode).
- R2: A write at offset 0x14 + 2*i loads channel i (i = 0..3, so offsets 0x14, 0x16, 0x18, 0x1A). Only bits 11:0 of the write data are kept.
- R3: In buffered mode, a data write leaves every output code unchanged until an update read.
- R4: A read at offset 0x02 copies all four shadow data registers to the active registers on the same clock edge. The new codes appear on the outputs in the cycle after the read strobe.
- R5: In direct mode, a data write to channel i changes that channel's output code in the cycle after the write strobe.
- R6: A write at offset 0x02 loads the mode register: bit 1 = 1 enables the converters, and bit 0 = 1 selects buffered mode. While the converters are disabled, every output code reads 0. The stored active values return when the converters are enabled again.
- R7: A write at offset 0x12 loads the control shadow only. The bipolar and gain outputs change only on a read at offset 0x12, which copies the whole control shadow to the outputs.
- R8: In the control word, the bipolar flag of channel i is bit 7-i and the gain flag of channel i is bit 11-i (channel 0 uses bits 7 and 11; channel 3 uses bits 4 and 8).
- R9: When a write and an update read fall in the same cycle, the update moves the shadow as it stood before that edge, and the written value stays in the shadow for the next update. This holds for both data and control. In direct mode, the data write reaches the output.
- R10: Writes and reads at any other offset have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read (update command) strobe |
| rd_addr | input | 8 | Read byte offset |
| dac_code | output | 48 | Output codes, channel i at bits 12*i+11 : 12*i |
| dac_bipolar | output | 4 | Active bipolar flag per channel, bit i = channel i |
| dac_gain | output | 4 | Active gain flag per channel, bit i = channel i |

## Verification
A data write and an update read can land in the same cycle because the two strobes are independent ports. The same is true of a control write and a control update read.

The bench drives both strobes in one cycle. In buffered mode it expects the outputs to show the shadow as it stood before that edge. A second update read must then bring out the value written during the collision. In direct mode it expects the colliding write to win on its own channel.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    localparam int NCH      = 4;
    localparam int CODE_W   = 12;
    localparam int BUS_W    = 16;
    localparam int ADDR_W   = 8;
    localparam int BIP_TOP  = 7;
    localparam int GAIN_TOP = 11;
    localparam int EN_BIT   = 1;
    localparam int BUF_BIT  = 0;

    localparam logic [ADDR_W-1:0] OFS_MODE  = 8'h02;
    localparam logic [ADDR_W-1:0] OFS_CTL   = 8'h12;
    localparam logic [ADDR_W-1:0] OFS_DATA0 = 8'h14;

    typedef logic [NCH-1:0][CODE_W-1:0] codes_t;

    typedef struct packed {
        logic [NCH-1:0] bip;
        logic [NCH-1:0] gain;
    } chctl_t;

    typedef struct packed {
        logic [NCH-1:0] data_wr;
        logic           mode_wr;
        logic           ctl_wr;
        logic           data_upd;
        logic           ctl_upd;
    } strobe_t;
endpackage

// File: rtl/qdac_decode.sv
module qdac_decode
    import qdac_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output strobe_t           strb
);
    always_comb begin
        strb = '0;
        for (int i = 0; i < NCH; i++) begin
            strb.data_wr[i] = wr_en && (wr_addr == ADDR_W'(int'(OFS_DATA0) + 2 * i));
        end
        strb.mode_wr  = wr_en && (wr_addr == OFS_MODE);
        strb.ctl_wr   = wr_en && (wr_addr == OFS_CTL);
        strb.data_upd = rd_en && (rd_addr == OFS_MODE);
        strb.ctl_upd  = rd_en && (rd_addr == OFS_CTL);
    end
endmodule

// File: rtl/qdac_mode.sv
module qdac_mode
    import qdac_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [BUS_W-1:0] wdata,
    output logic             enable,
    output logic             buffered
);
    typedef struct packed {
        logic en;
        logic buff;
    } mode_t;

    mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (mode_wr) begin
            mode_d.en   = wdata[EN_BIT];
            mode_d.buff = wdata[BUF_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    assign enable   = mode_q.en;
    assign buffered = mode_q.buff;

    p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> $stable(mode_q));
endmodule

// File: rtl/qdac_ctl.sv
module qdac_ctl
    import qdac_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_upd,
    input  logic [BUS_W-1:0] wdata,
    output chctl_t           active
);
    typedef struct packed {
        chctl_t shadow;
        chctl_t active;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl_upd) begin
            st_d.active = st_q.shadow;
        end
        if (ctl_wr) begin
            for (int i = 0; i < NCH; i++) begin
                st_d.shadow.bip[i]  = wdata[BIP_TOP - i];
                st_d.shadow.gain[i] = wdata[GAIN_TOP - i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;

    p_ctl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_upd |=> $stable(st_q.active));
    p_ctl_upd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_upd |=> (st_q.active == $past(st_q.shadow)));
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank
    import qdac_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   data_wr,
    input  logic             data_upd,
    input  logic             buffered,
    input  logic [BUS_W-1:0] wdata,
    output codes_t           active
);
    typedef struct packed {
        codes_t shadow;
        codes_t active;
    } bank_t;

    bank_t bk_d, bk_q;
    logic [CODE_W-1:0] code_in;

    assign code_in = wdata[CODE_W-1:0];

    always_comb begin
        bk_d = bk_q;
        if (data_upd) begin
            bk_d.active = bk_q.shadow;
        end
        for (int i = 0; i < NCH; i++) begin
            if (data_wr[i]) begin
                bk_d.shadow[i] = code_in;
                if (!buffered) bk_d.active[i] = code_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign active = bk_q.active;

    p_buf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (buffered && !data_upd) |=> $stable(bk_q.active));
    p_upd_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (buffered && data_upd) |=> (bk_q.active == $past(bk_q.shadow)));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        p_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!buffered && data_wr[g]) |=> (bk_q.active[g] == $past(code_in)));
    end
endmodule

// File: rtl/quad_dac_regs.sv
module quad_dac_regs
    import qdac_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [BUS_W-1:0]      wr_data,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [NCH*CODE_W-1:0] dac_code,
    output logic [NCH-1:0]        dac_bipolar,
    output logic [NCH-1:0]        dac_gain
);
    strobe_t strb;
    logic    enable;
    logic    buffered;
    chctl_t  ctl_act;
    codes_t  codes;

    qdac_decode u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .strb    (strb)
    );

    qdac_mode u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_wr  (strb.mode_wr),
        .wdata    (wr_data),
        .enable   (enable),
        .buffered (buffered)
    );

    qdac_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_wr  (strb.ctl_wr),
        .ctl_upd (strb.ctl_upd),
        .wdata   (wr_data),
        .active  (ctl_act)
    );

    qdac_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_wr  (strb.data_wr),
        .data_upd (strb.data_upd),
        .buffered (buffered),
        .wdata    (wr_data),
        .active   (codes)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_out
        assign dac_code[g*CODE_W +: CODE_W] = enable ? codes[g] : '0;
    end

    assign dac_bipolar = ctl_act.bip;
    assign dac_gain    = ctl_act.gain;

    p_onehot_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb.data_wr));
    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en || rd_en) |=> ($stable(dac_code) && $stable(dac_bipolar) && $stable(dac_gain)));
endmodule

// File: tb/test_quad_dac_regs.sv
module test_quad_dac_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [47:0] dac_code;
    logic [3:0]  dac_bipolar;
    logic [3:0]  dac_gain;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    quad_dac_regs i_quad_dac_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .dac_code(dac_code), .dac_bipolar(dac_bipolar), .dac_gain(dac_gain)
    );

    function automatic logic [47:0] pk(input logic [11:0] a, b, c, d);
        return {d, c, b, a};
    endfunction

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input bit w, input logic [7:0] wa, input logic [15:0] wd,
                       input bit r, input logic [7:0] ra);
        @(negedge clk);
        wr_en = w; wr_addr = wa; wr_data = wd; rd_en = r; rd_addr = ra;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        cyc(1'b1, a, d, 1'b0, 8'h00);
    endtask

    task automatic rd(input logic [7:0] a);
        cyc(1'b0, 8'h00, 16'h0, 1'b1, a);
    endtask

    task automatic t_reset;
        chk("R1 codes", dac_code, 48'h0);
        chk("R1 bipolar", {44'h0, dac_bipolar}, 48'h0);
        chk("R1 gain", {44'h0, dac_gain}, 48'h0);
        wr(8'h16, 16'h0123);
        chk("R1 disabled after reset", dac_code, 48'h0);
    endtask

    task automatic t_direct;
        wr(8'h02, 16'h0002);
        chk("R5 enable shows direct write", dac_code, pk(12'h0, 12'h123, 12'h0, 12'h0));
        wr(8'h16, 16'hFABC);
        chk("R2 R5 ch1 low 12 bits", dac_code, pk(12'h0, 12'hABC, 12'h0, 12'h0));
        wr(8'h1A, 16'h1DEF);
        chk("R2 ch3 offset 0x1A", dac_code, pk(12'h0, 12'hABC, 12'h0, 12'hDEF));
    endtask

    task automatic t_buffered;
        wr(8'h02, 16'h0003);
        wr(8'h14, 16'h0111);
        wr(8'h18, 16'h0333);
        wr(8'h1A, 16'h0444);
        chk("R3 outputs held", dac_code, pk(12'h0, 12'hABC, 12'h0, 12'hDEF));
        rd(8'h02);
        chk("R4 all four update", dac_code, pk(12'h111, 12'hABC, 12'h333, 12'h444));
    endtask

    task automatic t_disable;
        wr(8'h02, 16'h0001);
        chk("R6 disabled zero", dac_code, 48'h0);
        wr(8'h02, 16'h0003);
        chk("R6 values return", dac_code, pk(12'h111, 12'hABC, 12'h333, 12'h444));
    endtask

    task automatic t_ctl;
        wr(8'h12, 16'h08A0);
        chk("R7 bipolar held", {44'h0, dac_bipolar}, 48'h0);
        chk("R7 gain held", {44'h0, dac_gain}, 48'h0);
        rd(8'h12);
        chk("R8 bipolar A C", {44'h0, dac_bipolar}, 48'h5);
        chk("R8 gain A", {44'h0, dac_gain}, 48'h1);
        wr(8'h12, 16'h0410);
        rd(8'h12);
        chk("R8 bipolar D", {44'h0, dac_bipolar}, 48'h8);
        chk("R8 gain B", {44'h0, dac_gain}, 48'h2);
    endtask

    task automatic t_ignore;
        wr(8'h04, 16'hFFFF);
        wr(8'h13, 16'hFFFF);
        wr(8'h1C, 16'hFFFF);
        wr(8'h00, 16'hFFFF);
        rd(8'h00);
        rd(8'h04);
        rd(8'h14);
        chk("R10 codes unchanged", dac_code, pk(12'h111, 12'hABC, 12'h333, 12'h444));
        chk("R10 control unchanged", {40'h0, dac_gain, dac_bipolar}, 48'h28);
        rd(8'h02);
        chk("R10 shadows untouched", dac_code, pk(12'h111, 12'hABC, 12'h333, 12'h444));
    endtask

    task automatic t_collision;
        cyc(1'b1, 8'h14, 16'h0555, 1'b1, 8'h02);
        chk("R9 update uses old shadow", dac_code, pk(12'h111, 12'hABC, 12'h333, 12'h444));
        rd(8'h02);
        chk("R9 new write kept", dac_code, pk(12'h555, 12'hABC, 12'h333, 12'h444));
        cyc(1'b1, 8'h12, 16'h0F00, 1'b1, 8'h12);
        chk("R9 ctl update uses old shadow", {40'h0, dac_gain, dac_bipolar}, 48'h28);
        rd(8'h12);
        chk("R9 ctl new write kept", {40'h0, dac_gain, dac_bipolar}, 48'hF0);
        wr(8'h02, 16'h0002);
        cyc(1'b1, 8'h1A, 16'h0777, 1'b1, 8'h02);
        chk("R9 direct write wins", dac_code, pk(12'h555, 12'hABC, 12'h333, 12'h777));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_buffered();
        t_disable();
        t_ctl();
        t_ignore();
        t_collision();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule